// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller

This block is the digital sequencer of a successive-approximation analog-to-digital converter. A divider slows the system clock down to a conversion tick, selectable from six ratios. On each accepted start the controller captures its settings, spends a fixed number of ticks in a sampling phase, and then resolves the result one bit per tick. It starts at the most significant bit. It drives the trial code onto a DAC output and reads back a single comparator input. Resolution is either 8 or 10 bits. The sampling length depends on both the resolution and on whether the sample-and-hold path is in use, so that each conversion lasts the fixed tick count given for that setting.

One of eight channels is selected per conversion, and each channel has its own result register, read through a combinational read port. A done flag pulses when a result register is written. In one-shot mode the controller then returns to idle. In repeat mode it starts a new sampling phase in the same cycle. Starts are accepted only while idle and only while the reference-connect input is high. When the converter is unused, software drops the reference-connect input so that the external ladder is disconnected.

Top module: `sar_adc_ctrl`

## Requirements
- R1: The tick ratio follows `divSel`: 0 divides by 1, 1 by 2, 2 by 3, 3 by 4, 4 by 6, and 5, 6 and 7 by 12. A conversion lasts T×N clock cycles, where N is the ratio captured at start. This is counted from the clock edge that accepts `start` to the edge after which `done` reads 1.
- R2: T, in ticks, is 49 for 8 bits without sample-and-hold and 59 for 10 bits without it. With sample-and-hold, T is 28 for 8 bits and 33 for 10 bits. `res10` = 1 selects 10 bits and `shEn` = 1 selects sample-and-hold.
- R3: The search runs from the MSB down. Each step sets its trial bit on `dacCode`. At the end of the step the bit is kept if `compIn` is 1 (input at or above the DAC level) and cleared if `compIn` is 0. With a comparator that compares an input V against `dacCode`, the result is V, saturated at the full scale of the selected resolution.
- R4: In 8-bit mode, bits 9:8 of `dacCode` and of the stored result are zero.
- R5: The result is written only to the register of the channel that `chanSel` held at start; the other seven are unchanged. `readData` shows the register selected by `readSel`. All registers reset to 0.
- R6: `done` is high for exactly one cycle per conversion, in the cycle after the result register is written. `busy` is high from the accepting edge until the end of a one-shot conversion.
- R7: A `start` that arrives while `busy` is high is ignored. It changes neither the timing, nor the channel, nor the result of the running conversion.
- R8: A `start` while `refConnect` is 0 is ignored, and `busy` stays 0.
- R9: In repeat mode (`repeatMode` = 1 when a conversion ends), a new conversion with the captured settings begins at once, and `done` recurs every T×N cycles. If `repeatMode` is 0 when a conversion ends, the controller goes idle.
- R10: `sampleOn` is high during the sampling phase only if `shEn` was 1 at start. It is low during the bit trials and while idle.
- R11: After reset, `busy`, `done`, `sampleOn` and `dacCode` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Conversion start strobe |
| refConnect | input | 1 | Reference connected to ladder; starts are gated by it |
| res10 | input | 1 | 1 selects 10-bit, 0 selects 8-bit resolution |
| shEn | input | 1 | Sample-and-hold enable |
| repeatMode | input | 1 | 1 repeats conversions, 0 runs one shot |
| chanSel | input | 3 | Channel to convert |
| divSel | input | 3 | Tick divider select |
| compIn | input | 1 | Comparator: 1 when input is at or above DAC level |
| readSel | input | 3 | Result register to read |
| dacCode | output | 10 | Trial code for the DAC |
| sampleOn | output | 1 | Sample-and-hold control |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle result-written pulse |
| readData | output | 10 | Result register selected by readSel |

## Verification
The bench builds the block with its default parameters: 8 channels, 10 and 8 bit resolutions, and the stated tick totals. This brings every divider ratio within reach, including the largest, 59 ticks at a ratio of 12, which is 708 cycles. Random conversions mix channel, resolution, sample-and-hold, ratio and input level. Directed cases cover full-scale and zero inputs, 8-bit saturation, the unused divider codes, starts during a busy conversion or with the reference disconnected, and the repeat-mode interval and exit.

// File: rtl/sar_pkg.sv
package sar_pkg;
  parameter int unsigned SAR_MAX_BITS = 10;
  localparam int unsigned SAR_IDX_W = $clog2(SAR_MAX_BITS);

  typedef struct packed {
    logic                 initConv;
    logic                 setTrial;
    logic [SAR_IDX_W-1:0] trialIdx;
    logic                 decide;
    logic [SAR_IDX_W-1:0] decIdx;
    logic                 commit;
  } sarStrobe_t;
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
  parameter int unsigned DIV_W = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       restart,
  input  logic       run,
  input  logic [2:0] divSel,
  output logic       tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] ratioLat;

  function automatic logic [DIV_W-1:0] divRatio(input logic [2:0] sel);
    case (sel)
      3'd0:    return DIV_W'(1);
      3'd1:    return DIV_W'(2);
      3'd2:    return DIV_W'(3);
      3'd3:    return DIV_W'(4);
      3'd4:    return DIV_W'(6);
      default: return DIV_W'(12);
    endcase
  endfunction

  assign tick = run && (cnt == ratioLat - DIV_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      ratioLat <= DIV_W'(1);
    end else if (restart) begin
      cnt      <= '0;
      ratioLat <= divRatio(divSel);
    end else if (run) begin
      cnt <= tick ? '0 : cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned RES_HI   = 10,
  parameter int unsigned RES_LO   = 8,
  parameter int unsigned CH_W     = 3,
  parameter int unsigned T_LO_RAW = 49,
  parameter int unsigned T_HI_RAW = 59,
  parameter int unsigned T_LO_SH  = 28,
  parameter int unsigned T_HI_SH  = 33
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            refConnect,
  input  logic            res10,
  input  logic            shEn,
  input  logic            repeatMode,
  input  logic [CH_W-1:0] chanSel,
  input  logic            tick,
  output sarStrobe_t      strb,
  output logic [CH_W-1:0] chanLat,
  output logic            restart,
  output logic            busy,
  output logic            done,
  output logic            sampleOn
);
  localparam int unsigned CNT_W = $clog2(T_LO_RAW + T_HI_RAW + T_LO_SH + T_HI_SH);

  typedef enum logic [1:0] {IDLE, SAMPLE, CONVERT} ctrlState_t;

  ctrlState_t           state;
  logic [CNT_W-1:0]     cnt;
  logic [SAR_IDX_W-1:0] bitIdx;
  logic                 resLat;
  logic                 shLat;
  logic                 accept;
  logic                 convEnd;

  function automatic logic [CNT_W-1:0] sampLoad(input logic hi, input logic sh);
    int t;
    if (sh) t = hi ? int'(T_HI_SH) : int'(T_LO_SH);
    else    t = hi ? int'(T_HI_RAW) : int'(T_LO_RAW);
    t = t - (hi ? int'(RES_HI) : int'(RES_LO)) - 1;
    return CNT_W'(t);
  endfunction

  function automatic logic [SAR_IDX_W-1:0] msbIdx(input logic hi);
    return hi ? SAR_IDX_W'(RES_HI - 1) : SAR_IDX_W'(RES_LO - 1);
  endfunction

  assign accept  = start && refConnect && (state == IDLE);
  assign convEnd = (state == CONVERT) && tick && (bitIdx == '0);

  always_comb begin
    strb          = '0;
    strb.initConv = accept || (convEnd && repeatMode);
    strb.decide   = (state == CONVERT) && tick;
    strb.decIdx   = bitIdx;
    strb.commit   = convEnd;
    if (state == SAMPLE) begin
      strb.setTrial = tick && (cnt == '0);
      strb.trialIdx = msbIdx(resLat);
    end else if (state == CONVERT) begin
      strb.setTrial = tick && (bitIdx != '0);
      strb.trialIdx = bitIdx - SAR_IDX_W'(1);
    end
  end

  assign restart  = accept;
  assign busy     = (state != IDLE);
  assign sampleOn = (state == SAMPLE) && shLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= IDLE;
      cnt     <= '0;
      bitIdx  <= '0;
      resLat  <= 1'b0;
      shLat   <= 1'b0;
      chanLat <= '0;
      done    <= 1'b0;
    end else begin
      done <= convEnd;
      case (state)
        IDLE: if (accept) begin
          state   <= SAMPLE;
          cnt     <= sampLoad(res10, shEn);
          resLat  <= res10;
          shLat   <= shEn;
          chanLat <= chanSel;
        end
        SAMPLE: if (tick) begin
          if (cnt == '0) begin
            state  <= CONVERT;
            bitIdx <= msbIdx(resLat);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        CONVERT: if (tick) begin
          if (bitIdx == '0) begin
            if (repeatMode) begin
              state <= SAMPLE;
              cnt   <= sampLoad(resLat, shLat);
            end else begin
              state <= IDLE;
            end
          end else begin
            bitIdx <= bitIdx - SAR_IDX_W'(1);
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath
  import sar_pkg::*;
#(
  parameter int unsigned RES_HI   = 10,
  parameter int unsigned NUM_CHAN = 8,
  parameter int unsigned CH_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  sarStrobe_t        strb,
  input  logic              compIn,
  input  logic [CH_W-1:0]   chanLat,
  input  logic [CH_W-1:0]   readSel,
  output logic [RES_HI-1:0] dacCode,
  output logic [RES_HI-1:0] readData
);
  logic [RES_HI-1:0] sar;
  logic [RES_HI-1:0] decided;
  logic [RES_HI-1:0] sarNext;
  logic [RES_HI-1:0] resultQ [NUM_CHAN];

  always_comb begin
    decided = sar;
    if (strb.decide) decided[strb.decIdx] = compIn;
    sarNext = decided;
    if (strb.setTrial) sarNext[strb.trialIdx] = 1'b1;
    if (strb.initConv) sarNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sar <= '0;
    else       sar <= sarNext;
  end

  for (genvar g = 0; g < NUM_CHAN; g++) begin : gResult
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        resultQ[g] <= '0;
      else if (strb.commit && (chanLat == CH_W'(g)))
        resultQ[g] <= decided;
    end
  end

  assign dacCode  = sar;
  assign readData = resultQ[readSel];
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
#(
  parameter int unsigned RES_HI   = SAR_MAX_BITS,
  parameter int unsigned RES_LO   = 8,
  parameter int unsigned NUM_CHAN = 8,
  parameter int unsigned DIV_W    = 4,
  parameter int unsigned T_LO_RAW = 49,
  parameter int unsigned T_HI_RAW = 59,
  parameter int unsigned T_LO_SH  = 28,
  parameter int unsigned T_HI_SH  = 33,
  localparam int unsigned CH_W    = $clog2(NUM_CHAN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              refConnect,
  input  logic              res10,
  input  logic              shEn,
  input  logic              repeatMode,
  input  logic [CH_W-1:0]   chanSel,
  input  logic [2:0]        divSel,
  input  logic              compIn,
  input  logic [CH_W-1:0]   readSel,
  output logic [RES_HI-1:0] dacCode,
  output logic              sampleOn,
  output logic              busy,
  output logic              done,
  output logic [RES_HI-1:0] readData
);
  sarStrobe_t      strb;
  logic            tick;
  logic            restart;
  logic [CH_W-1:0] chanLat;

  sar_clkdiv #(.DIV_W(DIV_W)) uDiv (
    .clk(clk), .rstN(rstN), .restart(restart), .run(busy),
    .divSel(divSel), .tick(tick)
  );

  sar_ctrl #(
    .RES_HI(RES_HI), .RES_LO(RES_LO), .CH_W(CH_W),
    .T_LO_RAW(T_LO_RAW), .T_HI_RAW(T_HI_RAW), .T_LO_SH(T_LO_SH), .T_HI_SH(T_HI_SH)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .refConnect(refConnect),
    .res10(res10), .shEn(shEn), .repeatMode(repeatMode), .chanSel(chanSel),
    .tick(tick), .strb(strb), .chanLat(chanLat), .restart(restart),
    .busy(busy), .done(done), .sampleOn(sampleOn)
  );

  sar_datapath #(.RES_HI(RES_HI), .NUM_CHAN(NUM_CHAN), .CH_W(CH_W)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .compIn(compIn), .chanLat(chanLat),
    .readSel(readSel), .dacCode(dacCode), .readData(readData)
  );
endmodule

// File: rtl/sar_adc_ctrl_chk.sv
module sar_adc_ctrl_chk #(
  parameter int unsigned RES_HI = 10,
  parameter int unsigned CH_W   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              refConnect,
  input logic              busy,
  input logic              done,
  input logic              sampleOn,
  input logic [RES_HI-1:0] dacCode,
  input logic [CH_W-1:0]   readSel,
  input logic [RES_HI-1:0] readData
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R6

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy)); // R6

  AST_NO_REF_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !refConnect) |=> !busy); // R8

  AST_SAMPLE_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    sampleOn |-> busy); // R10

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(readSel) && !done) |-> $stable(readData)); // R5

  AST_DAC_IDLE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !$past(busy)) |-> $stable(dacCode)); // R3

  AST_IDLE_START_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && refConnect) |=> busy); // R7
endmodule

bind sar_adc_ctrl sar_adc_ctrl_chk #(.RES_HI(RES_HI), .CH_W(CH_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .refConnect(refConnect), .busy(busy),
  .done(done), .sampleOn(sampleOn), .dacCode(dacCode), .readSel(readSel),
  .readData(readData)
);

// File: tb/tb_sar_adc_ctrl.sv
`timescale 1ns/1ps
module tb_sar_adc_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, refConnect = 1'b1, res10 = 1'b1, shEn = 1'b0, repeatMode = 1'b0;
  logic [2:0] chanSel = '0, divSel = '0, readSel = '0;
  logic compIn;
  logic [9:0] dacCode, readData;
  logic sampleOn, busy, done;
  logic [9:0] vin = '0;
  logic [9:0] shadow [8];
  int nChecks = 0, nFails = 0, doneCount = 0;

  always #10 clk = ~clk;
  assign compIn = (dacCode <= vin);
  always @(negedge clk) if (rstN && done) doneCount++;

  sar_adc_ctrl dut (
    .clk(clk), .rstN(rstN), .start(start), .refConnect(refConnect), .res10(res10),
    .shEn(shEn), .repeatMode(repeatMode), .chanSel(chanSel), .divSel(divSel),
    .compIn(compIn), .readSel(readSel), .dacCode(dacCode), .sampleOn(sampleOn),
    .busy(busy), .done(done), .readData(readData)
  );

  function automatic int ratioOf(input logic [2:0] s);
    case (s)
      3'd0: return 1; 3'd1: return 2; 3'd2: return 3;
      3'd3: return 4; 3'd4: return 6; default: return 12;
    endcase
  endfunction

  function automatic int ticksOf(input logic hi, input logic sh);
    if (sh) return hi ? 33 : 28;
    return hi ? 59 : 49;
  endfunction

  function automatic logic [9:0] expectOf(input logic [9:0] v, input logic hi);
    if (!hi && v > 10'd255) return 10'd255;
    return v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
  endtask

  task automatic scanAll(input string req);
    for (int c = 0; c < 8; c++) begin
      readSel = 3'(c);
      #1;
      check(req, readData, shadow[c]);
    end
  endtask

  // One conversion; optional stray start part-way through (R7).
  task automatic convert(input logic [2:0] ch, input logic hi, input logic sh,
                         input logic [2:0] dv, input logic [9:0] v, input bit stray);
    int cycles = 0;
    int expCycles = ticksOf(hi, sh) * ratioOf(dv);
    @(negedge clk);
    chanSel = ch; res10 = hi; shEn = sh; divSel = dv; vin = v; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check("R6 busy after start", busy, 1);
    check("R10 sampleOn in sampling", sampleOn, sh);
    do begin
      @(posedge clk);
      cycles++;
      @(negedge clk);
      if (stray && cycles == 5) begin
        start = 1'b1; chanSel = ch + 3'd1; res10 = ~hi; divSel = 3'd0;
      end
      if (stray && cycles == 6) start = 1'b0;
    end while (!done && cycles < 2000);
    check(stray ? "R7 duration with stray start" : "R1 R2 duration", cycles, expCycles);
    check("R6 busy low at done", busy, 0);
    check("R10 sampleOn low when idle", sampleOn, 0);
    shadow[ch] = expectOf(v, hi);
    readSel = ch;
    #1;
    check("R3 result", readData, shadow[ch]);
    if (!hi) check("R4 upper bits zero", readData[9:8], 0);
    @(negedge clk);
    check("R6 done one cycle", done, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=hung expected=finish");
    summary();
    $finish;
  end

  initial begin
    int dc;
    void'($urandom(32'd4242));
    for (int c = 0; c < 8; c++) shadow[c] = '0;
    repeat (3) @(negedge clk);
    check("R11 busy reset", busy, 0);
    check("R11 done reset", done, 0);
    check("R11 sampleOn reset", sampleOn, 0);
    check("R11 dacCode reset", dacCode, 0);
    rstN = 1'b1;
    @(negedge clk);
    scanAll("R5 reset results");

    // Directed corners
    convert(3'd0, 1'b1, 1'b0, 3'd0, 10'd1023, 0);
    convert(3'd1, 1'b1, 1'b1, 3'd5, 10'd0, 0);
    convert(3'd2, 1'b0, 1'b0, 3'd7, 10'd1023, 0);
    convert(3'd3, 1'b0, 1'b1, 3'd6, 10'd255, 0);
    convert(3'd4, 1'b1, 1'b1, 3'd4, 10'd512, 1);
    convert(3'd7, 1'b0, 1'b0, 3'd1, 10'd128, 1);
    scanAll("R5 channel isolation");

    // R8: reference disconnected
    @(negedge clk);
    refConnect = 1'b0; dc = doneCount; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    check("R8 busy without reference", busy, 0);
    check("R8 no done without reference", doneCount, dc);
    refConnect = 1'b1;

    // Random conversions
    for (int i = 0; i < 40; i++) begin
      convert(3'($urandom % 8), 1'($urandom), 1'($urandom), 3'($urandom % 8),
              10'($urandom), (i % 3) == 0);
    end
    scanAll("R5 after random");

    // R9: repeat mode, ratio 2, 10 bits with sample-and-hold
    begin
      int cycles;
      @(negedge clk);
      chanSel = 3'd5; res10 = 1'b1; shEn = 1'b1; divSel = 3'd1; vin = 10'd300;
      repeatMode = 1'b1; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 3; k++) begin
        cycles = 0;
        do begin
          @(posedge clk); cycles++; @(negedge clk);
        end while (!done && cycles < 2000);
        check("R9 repeat interval", cycles, 66);
        readSel = 3'd5;
        #1;
        check("R9 repeat result", readData, vin);
        if (k == 0) begin
          check("R9 still busy in repeat", busy, 1);
          vin = 10'd777;
        end
        if (k == 1) repeatMode = 1'b0;
      end
      check("R9 idle after repeat cleared", busy, 0);
      dc = doneCount;
      repeat (200) @(negedge clk);
      check("R9 no further done", doneCount, dc);
      shadow[5] = 10'd777;
    end
    scanAll("R5 final");

    summary();
    $finish;
  end
endmodule